// File: doc/BRIEF.md
# Indexed Palette Colour Table with Sequenced Write Port

This block holds a 256-entry colour table, each entry an 8-bit red, green and blue value, and lets a processor fill it through two word registers on a 32-bit write bus. One register points at an entry. The other accepts colour bytes one after another. A small sequencer steers each byte to red, then green, then blue. After blue it advances to the next entry, so a stream of triples fills consecutive entries without rewriting the pointer.

The display pipeline reads the table through a separate lookup port. It presents an 8-bit pixel index and receives the stored triple one clock later. Bus reads of the register window always return zero.

Top module: `palette_dac`

## Requirements
- R1: The register is selected by byte address bits 3:2 only (the address taken within a 16-byte window, divided by 4). Word 0 is the pointer register and word 1 is the colour-data register. Words 2 and 3 change nothing on write. Address bits 1:0 and bits above bit 3 are ignored, so the window aliases.
- R2: A write to the pointer register (`wr_en` high, word 0) loads the entry pointer from `wr_data[31:24]` and sets the next component to red.
- R3: Successive writes to the colour-data register store `wr_data[31:24]` into the red, then green, then blue byte of the pointed entry. `wr_data[23:0]` is ignored.
- R4: The blue write advances the pointer by one modulo 256 (255 wraps to 0) and sets the next component back to red.
- R5: A pointer write in the middle of a triple discards the partial sequence, so the next data write goes to red of the new entry.
- R6: After reset, entries 0 to 254 are black (0,0,0) and entry 255 is white (255,255,255). The pointer is 0 and the next component is red.
- R7: The lookup port is registered. `lut_rgb` ({red[23:16], green[15:8], blue[7:0]}) shows the entry addressed by `lut_idx` at the previous rising edge. A colour write becomes visible one edge after the edge that stores it.
- R8: `bus_rdata` is zero at all times.
- R9: While `wr_en` is low, the address and data inputs change neither the table, the pointer, nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Single-cycle write strobe, no back-pressure |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data; the colour or pointer byte is in bits 31:24 |
| bus_rdata | output | 32 | Bus read data, always zero |
| lut_idx | input | 8 | Pixel index for the lookup port |
| lut_rgb | output | 24 | Looked-up colour {R,G,B}, one cycle after `lut_idx` |

## Verification
Pointer and sequence updates take effect at the edge that samples the write. A table write lands at that same edge. It shows on `lut_rgb` only after the following edge, because the read register is sampled before the store. The bench drives inputs on falling edges and samples on falling edges, so each lookup check follows exactly one rising edge after its index was set. The latency test samples the edge of a blue write, where the old blue byte is still expected, and the edge after it, where the new one is expected. Pointer and sequence state, which is not visible at the ports, is checked by bound properties one cycle after each write.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;
endpackage

// File: rtl/palette_dac_decode.sv
module palette_dac_decode #(
  parameter int BUS_AW    = 8,
  parameter int DATA_W    = 32,
  parameter int COMP_W    = 8,
  parameter int WIN_BYTES = 16
) (
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ptr_wr,
  output logic              dat_wr,
  output logic [COMP_W-1:0] wr_byte
);
  localparam int SEL_HI = $clog2(WIN_BYTES) - 1;
  localparam int SEL_W  = SEL_HI - 1;

  logic [SEL_W-1:0] sel;
  logic             unused_bits;

  assign sel     = wr_addr[SEL_HI:2];
  assign ptr_wr  = wr_en && (sel == SEL_W'(0));
  assign dat_wr  = wr_en && (sel == SEL_W'(1));
  assign wr_byte = wr_data[DATA_W-1 -: COMP_W];

  assign unused_bits = ^{wr_addr[BUS_AW-1:SEL_HI+1], wr_addr[1:0],
                         wr_data[DATA_W-COMP_W-1:0]};
endmodule

// File: rtl/palette_dac_seq.sv
module palette_dac_seq
  import palette_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic              dat_wr,
  input  logic [COMP_W-1:0] wr_byte,
  output logic [IDX_W-1:0]  cur_idx,
  output comp_e             cur_comp,
  output logic              lut_we
);
  logic [IDX_W-1:0] nxt_idx;
  comp_e            nxt_comp;
  logic             seq_en;

  assign seq_en = ptr_wr || dat_wr;

  always_comb begin
    nxt_idx  = cur_idx;
    nxt_comp = cur_comp;
    lut_we   = 1'b0;
    if (ptr_wr) begin
      nxt_idx  = wr_byte[COMP_W-1 -: IDX_W];
      nxt_comp = COMP_RED;
    end else if (dat_wr) begin
      case (cur_comp)
        COMP_RED: begin
          lut_we   = 1'b1;
          nxt_comp = COMP_GRN;
        end
        COMP_GRN: begin
          lut_we   = 1'b1;
          nxt_comp = COMP_BLU;
        end
        COMP_BLU: begin
          lut_we   = 1'b1;
          nxt_idx  = cur_idx + IDX_W'(1);
          nxt_comp = COMP_RED;
        end
        default: nxt_comp = COMP_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_comp <= COMP_RED;
    end else if (seq_en) begin
      cur_idx  <= nxt_idx;
      cur_comp <= nxt_comp;
    end
  end
endmodule

// File: rtl/palette_dac_lut.sv
module palette_dac_lut
  import palette_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  comp_e               wcomp,
  input  logic [COMP_W-1:0]   wbyte,
  input  logic [IDX_W-1:0]    ridx,
  output logic [3*COMP_W-1:0] rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W   = 3 * COMP_W;

  logic [RGB_W-1:0] ent_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [RGB_W-1:0] RST_VAL = (e == ENTRIES - 1) ? '1 : '0;
    logic             hit;
    logic [RGB_W-1:0] q;

    assign hit      = we && (widx == IDX_W'(e));
    assign ent_q[e] = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (hit) begin
        case (wcomp)
          COMP_RED: q[3*COMP_W-1 -: COMP_W] <= wbyte;
          COMP_GRN: q[2*COMP_W-1 -: COMP_W] <= wbyte;
          default:  q[COMP_W-1:0]           <= wbyte;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb <= '0;
    else        rgb <= ent_q[ridx];
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int BUS_AW    = 8,
  parameter int DATA_W    = 32,
  parameter int COMP_W    = 8,
  parameter int IDX_W     = 8,
  parameter int WIN_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BUS_AW-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]    lut_idx,
  output logic [3*COMP_W-1:0] lut_rgb
);
  logic              ptr_wr;
  logic              dat_wr;
  logic [COMP_W-1:0] wr_byte;
  logic [IDX_W-1:0]  cur_idx;
  comp_e             cur_comp;
  logic              lut_we;

  assign bus_rdata = '0;

  palette_dac_decode #(
    .BUS_AW(BUS_AW), .DATA_W(DATA_W), .COMP_W(COMP_W), .WIN_BYTES(WIN_BYTES)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_wr(ptr_wr), .dat_wr(dat_wr), .wr_byte(wr_byte)
  );

  palette_dac_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .dat_wr(dat_wr),
    .wr_byte(wr_byte), .cur_idx(cur_idx), .cur_comp(cur_comp),
    .lut_we(lut_we)
  );

  palette_dac_lut #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(lut_we), .widx(cur_idx),
    .wcomp(cur_comp), .wbyte(wr_byte), .ridx(lut_idx), .rgb(lut_rgb)
  );
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int BUS_AW = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BUS_AW-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        cur_comp
);
  logic ptr_sel, dat_sel, none_sel;
  assign ptr_sel  = wr_en && (wr_addr[3:2] == 2'd0);
  assign dat_sel  = wr_en && (wr_addr[3:2] == 2'd1);
  assign none_sel = !ptr_sel && !dat_sel;

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_sel |=> cur_idx == $past(wr_data[DATA_W-1 -: IDX_W]));
  // R2
  ptr_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_sel |=> cur_comp == 2'd0);
  // R3
  red_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_sel && cur_comp == 2'd0) |=> (cur_comp == 2'd1) && $stable(cur_idx));
  // R3
  grn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_sel && cur_comp == 2'd1) |=> (cur_comp == 2'd2) && $stable(cur_idx));
  // R4
  blu_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_sel && cur_comp == 2'd2) |=>
      (cur_comp == 2'd0) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_sel |=> $stable(cur_idx) && $stable(cur_comp));
  // R6
  comp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_comp != 2'd3);
endmodule

bind palette_dac palette_dac_chk #(
  .BUS_AW(BUS_AW), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cur_idx(cur_idx), .cur_comp(cur_comp)
);

// File: tb/palette_dac_bench.sv
`timescale 1ns/1ps
module palette_dac_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_idx;
  logic [23:0] lut_rgb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  palette_dac u_palette_dac (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_rdata(bus_rdata), .lut_idx(lut_idx),
    .lut_rgb(lut_rgb)
  );

  typedef struct packed {
    logic        look;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [23:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h10FFFFFF, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h11ABCDEF, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h22000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h33123456, 24'h0, 4'd0},
    '{1'b1, 8'h10, 32'h0,        24'h112233, 4'd3},
    '{1'b0, 8'h04, 32'h44000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h55000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h66000000, 24'h0, 4'd0},
    '{1'b1, 8'h11, 32'h0,        24'h445566, 4'd4},
    '{1'b0, 8'h08, 32'h77000000, 24'h0, 4'd0},
    '{1'b0, 8'h0C, 32'h88000000, 24'h0, 4'd0},
    '{1'b0, 8'h85, 32'h99000000, 24'h0, 4'd0},
    '{1'b0, 8'h16, 32'hAA000000, 24'h0, 4'd0},
    '{1'b0, 8'hF7, 32'hBB000000, 24'h0, 4'd0},
    '{1'b1, 8'h12, 32'h0,        24'h99AABB, 4'd1},
    '{1'b0, 8'h00, 32'h20000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'hC1000000, 24'h0, 4'd0},
    '{1'b0, 8'h40, 32'h20000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'hD1000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'hD2000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'hD3000000, 24'h0, 4'd0},
    '{1'b1, 8'h20, 32'h0,        24'hD1D2D3, 4'd5},
    '{1'b0, 8'h00, 32'hFF000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h01000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h02000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h03000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h04000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h05000000, 24'h0, 4'd0},
    '{1'b0, 8'h04, 32'h06000000, 24'h0, 4'd0},
    '{1'b1, 8'hFF, 32'h0,        24'h010203, 4'd4},
    '{1'b1, 8'h00, 32'h0,        24'h040506, 4'd4},
    '{1'b1, 8'h13, 32'h0,        24'h000000, 4'd1}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic look(input logic [7:0] i, input logic [23:0] exp,
                      input string req);
    @(negedge clk);
    lut_idx = i;
    @(negedge clk);
    check(req, {8'h0, lut_rgb}, {8'h0, exp});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; lut_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset contents
    look(8'h00, 24'h000000, "R6");
    look(8'h64, 24'h000000, "R6");
    look(8'hFF, 24'hFFFFFF, "R6");
    // R6 pointer 0 and red after reset
    bus_wr(8'h04, 32'hA0000000);
    bus_wr(8'h04, 32'hB0000000);
    bus_wr(8'h04, 32'hC0000000);
    look(8'h00, 24'hA0B0C0, "R6");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].look) look(VEC[v].addr, VEC[v].exp, tag(VEC[v].req));
      else             bus_wr(VEC[v].addr, VEC[v].data);
    end
    // R8
    check("R8", bus_rdata, 32'h0);

    // R7 latency around a blue write
    bus_wr(8'h00, 32'h40000000);
    bus_wr(8'h04, 32'h01000000);
    bus_wr(8'h04, 32'h02000000);
    @(negedge clk);
    lut_idx = 8'h40;
    wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h03000000;
    check("R8", bus_rdata, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", {8'h0, lut_rgb}, 32'h00010200);
    @(negedge clk);
    check("R7", {8'h0, lut_rgb}, 32'h00010203);
    lut_idx = 8'h10;
    #1;
    check("R7", {8'h0, lut_rgb}, 32'h00010203);
    @(negedge clk);
    check("R7", {8'h0, lut_rgb}, 32'h00112233);

    // R9 strobe low leaves everything alone
    bus_wr(8'h00, 32'h50000000);
    @(negedge clk);
    wr_addr = 8'h04; wr_data = 32'hEE000000;
    repeat (3) @(negedge clk);
    wr_addr = 8'h00; wr_data = 32'h60000000;
    repeat (2) @(negedge clk);
    look(8'h50, 24'h000000, "R9");
    bus_wr(8'h04, 32'h01000000);
    bus_wr(8'h04, 32'h02000000);
    bus_wr(8'h04, 32'h03000000);
    look(8'h50, 24'h010203, "R9");

    // R6 second reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    look(8'h10, 24'h000000, "R6");
    look(8'hFF, 24'hFFFFFF, "R6");

    finish_run();
  end
endmodule